// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the byte address for a single-register load or store in a 32-bit byte-addressed machine. It also forms the updated base value that a writeback would store.

The base is either a general register value or the program counter. The offset is either a 12-bit unsigned immediate or a second register value. The register offset may first be shifted or rotated. An up/down bit chooses whether the offset magnitude is added to or subtracted from the base.

Three indexing controls pick the mode:
- pre-indexed: the access uses base plus or minus offset, and the base is kept;
- pre-indexed with writeback: the same sum is used and is also written back;
- post-indexed: the access uses the untouched base, and the sum becomes the new base.

The access size is checked against the final address. A misaligned word or halfword raises a fault, and that fault cancels the writeback. All results are registered and appear one clock after the request.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are cleared to zero on that edge.
- R2: With `req_off_reg_sel`=0 the offset magnitude is `req_imm` zero-extended to 32 bits. With `req_off_reg_sel`=1 it is the shifted `req_roff`.
- R3: `req_shift_kind` selects the shift applied to `req_roff` by `req_shift_amt`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. An amount of 0 leaves the value unchanged.
- R4: With `req_up`=1 the sum is base plus offset, and with `req_up`=0 it is base minus offset, both modulo 2^32. `new_base` always carries this sum.
- R5: With `req_pre`=1 and `req_wb`=0, `mem_addr` is the sum and `base_we` is 0.
- R6: With `req_pre`=1 and `req_wb`=1, `mem_addr` is the sum and `base_we` is 1, unless R8 or R10 applies.
- R7: With `req_pre`=0, `mem_addr` is the base itself and `base_we` is 1 whatever `req_wb` is, unless R8 or R10 applies.
- R8: With `req_use_pc`=1 the base is `req_pc` instead of `req_base`, and `base_we` is 0.
- R9: `req_size` encodes 0 byte, 1 halfword, 2 word and 3 word. `align_fault` is 1 for a word with `mem_addr[1:0]`≠0 or for a halfword with `mem_addr[0]`=1. A byte never faults.
- R10: When `align_fault` is 1, `base_we` is 0.
- R11: Outputs reflect the request sampled on the previous clock edge. `out_valid` follows `req_valid` by one cycle, and with no request `base_we` and `align_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_base | input | 32 | Base register value |
| req_pc | input | 32 | Program counter value |
| req_use_pc | input | 1 | Use program counter as base |
| req_off_reg_sel | input | 1 | 1: register offset, 0: immediate offset |
| req_imm | input | 12 | Unsigned immediate offset |
| req_roff | input | 32 | Register offset value |
| req_shift_kind | input | 2 | Shift type for the register offset |
| req_shift_amt | input | 5 | Shift amount |
| req_up | input | 1 | 1 add offset, 0 subtract offset |
| req_pre | input | 1 | 1 pre-indexed, 0 post-indexed |
| req_wb | input | 1 | Writeback request in pre-indexed mode |
| req_size | input | 2 | Access size code |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Access address |
| new_base | output | 32 | Updated base value |
| base_we | output | 1 | Base writeback enable |
| align_fault | output | 1 | Misaligned access |

## Verification
A base writeback and an alignment fault can fall in the same cycle. This happens when a pre-indexed writeback or a post-indexed access lands on a misaligned word or halfword address. The sweep crosses odd and even bases, both offset sources with every shift type, both directions and all sizes, so many vectors hit this overlap. For each vector the bench computes the expected address, fault and writeback enable on its own, and it requires that the fault win over the writeback.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;
endpackage

// File: rtl/ea_shifter.sv
module ea_shifter #(
  parameter int XLEN = 32,
  parameter int SHW  = 5
) (
  input  logic [XLEN-1:0] val,
  input  logic [1:0]      kind,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] res
);
  import ea_pkg::*;
  localparam int AMTW = SHW + 1;
  logic [AMTW-1:0] back;

  always_comb begin
    back = AMTW'(XLEN) - AMTW'(amt);
    unique case (shift_e'(kind))
      SH_LSL:  res = val << amt;
      SH_LSR:  res = val >> amt;
      SH_ASR:  res = XLEN'($signed(val) >>> amt);
      default: res = (amt == '0) ? val : ((val >> amt) | (val << back));
    endcase
  end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  roff_sh,
  input  logic             use_reg,
  input  logic             up,
  output logic [XLEN-1:0]  sum
);
  logic [XLEN-1:0] mag;

  always_comb begin
    mag = use_reg ? roff_sh : {{(XLEN-IMM_W){1'b0}}, imm};
    sum = up ? (base + mag) : (base - mag);
  end
endmodule

// File: rtl/ea_align.sv
module ea_align #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] addr,
  input  logic [1:0]      size,
  output logic            fault
);
  import ea_pkg::*;

  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE: fault = 1'b0;
      SZ_HALF: fault = addr[0];
      default: fault = |addr[1:0];
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 12,
  parameter int SHW   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      req_base,
  input  logic [31:0]      req_pc,
  input  logic             req_use_pc,
  input  logic             req_off_reg_sel,
  input  logic [11:0]      req_imm,
  input  logic [31:0]      req_roff,
  input  logic [1:0]       req_shift_kind,
  input  logic [4:0]       req_shift_amt,
  input  logic             req_up,
  input  logic             req_pre,
  input  logic             req_wb,
  input  logic [1:0]       req_size,
  output logic             out_valid,
  output logic [31:0]      mem_addr,
  output logic [31:0]      new_base,
  output logic             base_we,
  output logic             align_fault
);
  logic [XLEN-1:0] base_sel, roff_sh, sum, addr_nx;
  logic            fault_nx, we_nx;

  assign base_sel = req_use_pc ? req_pc : req_base;

  ea_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .val  (req_roff),
    .kind (req_shift_kind),
    .amt  (req_shift_amt),
    .res  (roff_sh)
  );

  ea_sum #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sum (
    .base    (base_sel),
    .imm     (req_imm),
    .roff_sh (roff_sh),
    .use_reg (req_off_reg_sel),
    .up      (req_up),
    .sum     (sum)
  );

  assign addr_nx = req_pre ? sum : base_sel;

  ea_align #(.XLEN(XLEN)) u_align (
    .addr  (addr_nx),
    .size  (req_size),
    .fault (fault_nx)
  );

  assign we_nx = req_valid && !req_use_pc && (!req_pre || req_wb) && !fault_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      mem_addr    <= '0;
      new_base    <= '0;
      base_we     <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      out_valid   <= req_valid;
      mem_addr    <= addr_nx;
      new_base    <= sum;
      base_we     <= we_nx;
      align_fault <= req_valid && fault_nx;
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_base,
  input logic        req_use_pc,
  input logic        req_pre,
  input logic        req_wb,
  input logic [1:0]  req_size,
  input logic        out_valid,
  input logic [31:0] mem_addr,
  input logic        base_we,
  input logic        align_fault
);
  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !base_we && !align_fault));
  assert_fault_blocks_wb_R10: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !base_we);
  assert_byte_no_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd0) |=> !align_fault);
  assert_post_uses_base_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_pre && !req_use_pc) |=> (mem_addr == $past(req_base)));
  assert_pc_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_use_pc) |=> !base_we);
  assert_pre_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pre && !req_wb) |=> !base_we);
endmodule

bind ea_gen ea_gen_chk u_ea_gen_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_base    (req_base),
  .req_use_pc  (req_use_pc),
  .req_pre     (req_pre),
  .req_wb      (req_wb),
  .req_size    (req_size),
  .out_valid   (out_valid),
  .mem_addr    (mem_addr),
  .base_we     (base_we),
  .align_fault (align_fault)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0, req_pc = '0, req_roff = '0;
  logic        req_use_pc = 1'b0, req_off_reg_sel = 1'b0;
  logic [11:0] req_imm = '0;
  logic [1:0]  req_shift_kind = '0, req_size = '0;
  logic [4:0]  req_shift_amt = '0;
  logic        req_up = 1'b0, req_pre = 1'b0, req_wb = 1'b0;
  logic        out_valid, base_we, align_fault;
  logic [31:0] mem_addr, new_base;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
    .req_pc(req_pc), .req_use_pc(req_use_pc), .req_off_reg_sel(req_off_reg_sel),
    .req_imm(req_imm), .req_roff(req_roff), .req_shift_kind(req_shift_kind),
    .req_shift_amt(req_shift_amt), .req_up(req_up), .req_pre(req_pre),
    .req_wb(req_wb), .req_size(req_size), .out_valid(out_valid),
    .mem_addr(mem_addr), .new_base(new_base), .base_we(base_we),
    .align_fault(align_fault)
  );

  // R3: shift computed arithmetically
  function automatic logic [31:0] shifted(input logic [31:0] x, input int k, input int a);
    longint unsigned w;
    logic [31:0] r;
    w = longint'(x);
    case (k)
      0: r = 32'(w * (64'd1 << a));
      1: r = 32'(w / (64'd1 << a));
      2: begin
        r = 32'(w / (64'd1 << a));
        if (x[31]) for (int i = 0; i < a; i++) r[31-i] = 1'b1;
      end
      default: r = 32'((w / (64'd1 << a)) + ((w % (64'd1 << a)) * (64'd1 << (32 - a))));
    endcase
    return r;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  localparam logic [31:0] BASES [4] = '{32'h0000_1000, 32'h0000_1003, 32'hFFFF_FFFE, 32'h0000_0002};
  localparam logic [31:0] ROFFS [2] = '{32'h0000_0013, 32'h8000_0F01};
  localparam int AMTS [4] = '{0, 1, 4, 31};

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] b, mag, sum, ea;
    logic        exp_fault, exp_we;
    string       tag;
    // R1 reset state
    repeat (3) @(negedge clk);
    vectors++;
    if ({out_valid, base_we, align_fault} != 3'b000 || mem_addr != 0 || new_base != 0)
      fail_line("R1", "reset outputs", {out_valid, base_we, align_fault}, 0);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid || base_we || align_fault)
      fail_line("R11", "idle after reset", {out_valid, base_we, align_fault}, 0);

    for (int ib = 0; ib < 4; ib++)
    for (int ir = 0; ir < 2; ir++)
    for (int md = 0; md < 8; md++)
    for (int up = 0; up < 2; up++)
    for (int src = 0; src < 2; src++)
    for (int sz = 0; sz < 4; sz++)
    for (int k = 0; k < 4; k++)
    for (int ia = 0; ia < 4; ia++) begin
      if (src == 0 && (k != 0 || ia != 0)) continue;
      req_valid = 1'b1;
      req_base = BASES[ib];
      req_pc = BASES[ib] ^ 32'h0040_0001;
      req_roff = ROFFS[ir];
      req_imm = ROFFS[ir][11:0] ^ 12'h0A5;
      req_pre = md[0]; req_wb = md[1]; req_use_pc = md[2];
      req_up = up[0]; req_off_reg_sel = src[0];
      req_size = 2'(sz); req_shift_kind = 2'(k); req_shift_amt = 5'(AMTS[ia]);
      // expected (R2, R3, R4)
      b = req_use_pc ? req_pc : req_base;
      mag = src[0] ? shifted(req_roff, k, AMTS[ia]) : {20'd0, req_imm};
      sum = up[0] ? b + mag : b - mag;
      ea = req_pre ? sum : b;                           // R5 R6 R7
      exp_fault = (sz == 1) ? ea[0] : (sz >= 2) ? (ea[1:0] != 0) : 1'b0;  // R9
      exp_we = !req_use_pc && (!req_pre || req_wb) && !exp_fault;        // R8 R10
      tag = req_use_pc ? "R8" : !req_pre ? "R7" : req_wb ? "R6" : "R5";
      @(negedge clk);
      vectors++;
      if (!out_valid) fail_line("R11", "out_valid", out_valid, 1);
      if (mem_addr != ea) fail_line({tag, " R2 R3 R4"}, "mem_addr", mem_addr, ea);
      if (new_base != sum) fail_line("R4 R2 R3", "new_base", new_base, sum);
      if (align_fault != exp_fault) fail_line("R9", "align_fault", align_fault, exp_fault);
      if (base_we != exp_we) fail_line(exp_fault ? "R10" : tag, "base_we", base_we, exp_we);
    end

    // R11 request removed: quiet outputs
    req_valid = 1'b0;
    req_size = 2'd2; req_base = 32'h0000_0003; req_pre = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid || base_we || align_fault)
      fail_line("R11", "idle outputs", {out_valid, base_we, align_fault}, 0);

    // R1 reset mid-stream clears outputs
    req_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    vectors++;
    if (out_valid || mem_addr != 0 || new_base != 0 || base_we || align_fault)
      fail_line("R1", "reset clears", mem_addr, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule